// File: doc/BRIEF.md
# Phase-Synchronizable PWM Channel

This block is one channel of a multi-channel PWM generator. An up-counting time base runs from zero to a programmed period and wraps, so each PWM period lasts period+1 clock ticks. The output goes high at count zero and low when the count matches a compare value. New period and compare values are first written to shadow copies. They are copied to the active registers only at a zero event, so a waveform never sees a half-updated setting.

Several channels can be chained so that they keep fixed phase relations. A channel run as a master ignores its sync input and emits a one-cycle pulse each time its counter is zero. A channel run as a slave reloads its counter from a phase register on every sync input pulse, so its offset is enforced again in every period. Its sync output can either emit its own zero pulse or pass the incoming pulse straight on to the next channel. For a 90-degree offset, set the phase value to a quarter of the period.

A time-base enable is shared by all channels. While it is low, counters hold still and software can preset them, so channels released together keep their preset offsets.

Top module: `pwm_phase_chan`

## Requirements
- R1: After reset the counter is 0, the active and shadow period are PRD_RST, the active and shadow compare are CMP_RST, and the phase register is PHS_RST. With the enable low, pwm_out and sync_out are both 0.
- R2: While enabled, the counter steps by one each cycle. When it is at or above the active period it wraps to 0, so with sync_sel=0 the sync_out pulses are exactly period+1 cycles apart.
- R3: While enabled, pwm_out becomes 1 in the cycle after the counter is 0. It becomes 0 in the cycle after the counter equals the active compare; compare wins when both hold. So a compare of 0 keeps the output low, and a compare above the period keeps it high.
- R4: Writes to the period or compare change only the shadow copy. The copy moves to the active register on a zero event, which is a cycle that is enabled, has the counter at 0, and has no sync load and no counter preset.
- R5: While tb_en is 0, the counter, pwm_out and active registers hold, sync_in loads nothing, and sync_out in zero mode stays 0.
- R6: A counter preset write loads cnt_wdata into the counter on the next edge, whatever the enable is. It takes priority over counting and over a sync load.
- R7: With phase_en=1 and the enable high, a sync_in pulse loads the phase value into the counter on the next edge. With phase_en=0, sync_in has no effect on the counter.
- R8: sync_sel=0 drives sync_out high in every enabled cycle with the counter at 0. sync_sel=1 passes sync_in through to sync_out in the same cycle.
- R9: A phase value above the active period is loaded as the active period.
- R10: When a sync load falls in a cycle with the counter at 0, no shadow transfer takes place in that cycle. The pending value moves at the next zero event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | Shared time-base enable |
| sync_in | input | 1 | Sync pulse from the previous channel |
| phase_en | input | 1 | 1: slave (sync_in loads the phase value), 0: master |
| sync_sel | input | 1 | 0: pulse at counter zero, 1: pass sync_in through |
| prd_wr | input | 1 | Write strobe for the period shadow |
| prd_wdata | input | W | Period value |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| cmp_wdata | input | W | Compare value |
| phs_wr | input | 1 | Write strobe for the phase register |
| phs_wdata | input | W | Phase value |
| cnt_wr | input | 1 | Counter preset strobe |
| cnt_wdata | input | W | Counter preset value |
| pwm_out | output | 1 | PWM waveform |
| sync_out | output | 1 | Sync pulse to the next channel |

## Verification
A wrong counter value shows at sync_out within one period: the zero pulse comes early, comes late or is missing. A wrong active compare or period shows as a pwm_out edge in the wrong cycle within the same period. A shadow copy that loads at the wrong time has the same effect one period later than expected. A sync load that goes wrong, gets clamped wrongly, or is not blocked when it should be shows as a wrong gap to the next zero pulse, or as a compare edge in a period where it should not yet apply. The reference model follows every output in every cycle, so any of these is caught within about one period.

// File: rtl/pwm_pkg.sv
// Package: shared encodings for the phase-synchronizable PWM channel.
package pwm_pkg;
    // Source of the sync output
    typedef enum logic {
        SYNC_AT_ZERO = 1'b0,
        SYNC_PASS    = 1'b1
    } sync_sel_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
// Shadowed register: software writes land in the shadow copy. The shadow
// is copied to the active value only when xfer is high.
// Assumes xfer is already qualified as a zero event by the time base.
module pwm_shadow_reg #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         xfer,
    output logic [W-1:0] active
);
    localparam logic [W-1:0] RstV = W'(RST_VAL);

    logic [W-1:0] shadow_q;

    // Capture software writes into the shadow copy
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow_q <= RstV;
        else if (wr) shadow_q <= wdata;
    end

    // Copy the shadow into the active register on a zero event
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= RstV;
        else if (xfer) active <= shadow_q;
    end

    // R4: the active value moves only on a transfer
    a_r4_active_only_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(active));
endmodule

// File: rtl/pwm_timebase.sv
// Up-counting time base with a phase register, a sync reload and a preset.
// Priority: preset write, then sync load, then counting. Counting and sync
// loads need tb_en. Assumes prd_act is the active period.
module pwm_timebase #(
    parameter int W       = 16,
    parameter int PHS_RST = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tb_en,
    input  logic         sync_in,
    input  logic         phase_en,
    input  logic         phs_wr,
    input  logic [W-1:0] phs_wdata,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] prd_act,
    output logic [W-1:0] cnt,
    output logic         at_zero,
    output logic         zero_evt
);
    localparam logic [W-1:0] PhsRst = W'(PHS_RST);

    logic [W-1:0] phs_q;
    logic [W-1:0] phs_eff;
    logic         sync_load;

    // Phase register write
    always_ff @(posedge clk) begin
        if (!rst_n)      phs_q <= PhsRst;
        else if (phs_wr) phs_q <= phs_wdata;
    end

    // Clamp the phase to the active period; decode the events
    always_comb begin
        phs_eff   = (phs_q > prd_act) ? prd_act : phs_q;
        sync_load = tb_en && phase_en && sync_in;
        at_zero   = (cnt == '0);
        zero_evt  = tb_en && at_zero && !sync_load && !cnt_wr;
    end

    // Counter update: preset, sync reload, wrap or increment
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (cnt_wr)         cnt <= cnt_wdata;
        else if (tb_en) begin
            if (sync_load)       cnt <= phs_eff;
            else if (cnt >= prd_act) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
        end
    end

    // R5: with the enable low and no preset, the counter holds
    a_r5_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_en && !cnt_wr) |=> $stable(cnt));
    // R6: a preset write lands on the next edge
    a_r6_preset_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata)));
    // R9: a sync load never puts the counter above the period
    a_r9_load_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_load && !cnt_wr) |=> (cnt <= $past(prd_act)));
    // R7: with phase_en clear, counting goes on from the current value
    a_r7_master_ignores_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_en && !phase_en && !cnt_wr && cnt < prd_act) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_action.sv
// Action qualifier: sets the output at counter zero and clears it at a
// compare match. The match wins when both hold. Acts only while enabled.
module pwm_action #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tb_en,
    input  logic         at_zero,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_act,
    output logic         pwm
);
    logic at_cmp;

    // Compare match decode
    always_comb at_cmp = (cnt == cmp_act);

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)            pwm <= 1'b0;
        else if (tb_en) begin
            if (at_cmp)        pwm <= 1'b0;
            else if (at_zero)  pwm <= 1'b1;
        end
    end

    // R3: a rising edge follows a counter-zero cycle
    a_r3_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> $past(cnt) == '0);
    // R3: a falling edge follows a compare match
    a_r3_fall_at_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm) |-> $past(cnt) == $past(cmp_act));
endmodule

// File: rtl/pwm_phase_chan.sv
// One phase-synchronizable PWM channel: time base, shadowed period and
// compare, action qualifier and the sync output select.
// Assumes all inputs are synchronous to clk and that sync_in is one cycle wide.
module pwm_phase_chan #(
    parameter int W       = 16,
    parameter int PRD_RST = 9,
    parameter int CMP_RST = 5,
    parameter int PHS_RST = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tb_en,
    input  logic         sync_in,
    input  logic         phase_en,
    input  logic         sync_sel,
    input  logic         prd_wr,
    input  logic [W-1:0] prd_wdata,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         phs_wr,
    input  logic [W-1:0] phs_wdata,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic         pwm_out,
    output logic         sync_out
);
    import pwm_pkg::*;

    logic [W-1:0] prd_act;
    logic [W-1:0] cmp_act;
    logic [W-1:0] cnt;
    logic         at_zero;
    logic         zero_evt;
    sync_sel_e    sel;

    pwm_shadow_reg #(.W(W), .RST_VAL(PRD_RST)) u_prd (
        .clk(clk), .rst_n(rst_n), .wr(prd_wr), .wdata(prd_wdata),
        .xfer(zero_evt), .active(prd_act));

    pwm_shadow_reg #(.W(W), .RST_VAL(CMP_RST)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
        .xfer(zero_evt), .active(cmp_act));

    pwm_timebase #(.W(W), .PHS_RST(PHS_RST)) u_tb (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sync_in(sync_in),
        .phase_en(phase_en), .phs_wr(phs_wr), .phs_wdata(phs_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .prd_act(prd_act),
        .cnt(cnt), .at_zero(at_zero), .zero_evt(zero_evt));

    pwm_action #(.W(W)) u_aq (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .at_zero(at_zero),
        .cnt(cnt), .cmp_act(cmp_act), .pwm(pwm_out));

    // Sync output select: own zero pulse or pass sync_in through
    always_comb begin
        sel = sync_sel_e'(sync_sel);
        if (sel == SYNC_PASS) sync_out = sync_in;
        else                  sync_out = tb_en && at_zero;
    end

    // R10: a sync load in a zero cycle blocks the shadow transfer
    a_r10_load_blocks_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_en && phase_en && sync_in) |-> !zero_evt);
    // R5: in zero mode the sync output stays low while disabled
    a_r5_no_sync_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_en && !sync_sel) |-> !sync_out);
endmodule

// File: tb/pwm_phase_chan_tb_top.sv
// Bench: a behavioural reference model, compared with the outputs every cycle.
module pwm_phase_chan_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_en = 0, sync_in = 0, phase_en = 0, sync_sel = 0;
    logic prd_wr = 0, cmp_wr = 0, phs_wr = 0, cnt_wr = 0;
    logic [W-1:0] prd_wdata = 0, cmp_wdata = 0, phs_wdata = 0, cnt_wdata = 0;
    logic pwm_out, sync_out;

    always #5 clk = ~clk;

    pwm_phase_chan #(.W(W), .PRD_RST(9), .CMP_RST(5), .PHS_RST(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sync_in(sync_in),
        .phase_en(phase_en), .sync_sel(sync_sel), .prd_wr(prd_wr),
        .prd_wdata(prd_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .phs_wr(phs_wr), .phs_wdata(phs_wdata), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .pwm_out(pwm_out), .sync_out(sync_out));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string req = "R1";

    // reference model state
    int m_cnt, m_prd, m_prd_sh, m_cmp, m_cmp_sh, m_phs;
    bit m_pwm;
    int cyc = 0, last_sync = -1, gap = -1;

    task automatic check(string r, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_prd = 9; m_prd_sh = 9; m_cmp = 5; m_cmp_sh = 5; m_phs = 0; m_pwm = 0;
    endtask

    // One cycle: compare outputs, then advance the model across the edge
    task automatic step();
        bit e_sync, load, zev;
        int p_eff;
        #1;
        e_sync = sync_sel ? sync_in : (tb_en && m_cnt == 0);
        check(req, pwm_out, m_pwm, "pwm_out");
        check(req, sync_out, e_sync, "sync_out");
        if (sync_out && !sync_sel) begin
            if (last_sync >= 0) gap = cyc - last_sync;
            last_sync = cyc;
        end
        load = tb_en && phase_en && sync_in;
        zev = tb_en && m_cnt == 0 && !load && !cnt_wr;
        p_eff = (m_phs > m_prd) ? m_prd : m_phs;
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (tb_en) begin
                if (m_cnt == m_cmp) m_pwm = 0;
                else if (m_cnt == 0) m_pwm = 1;
            end
            if (cnt_wr) m_cnt = int'(cnt_wdata);
            else if (tb_en) begin
                if (load) m_cnt = p_eff;
                else if (m_cnt >= m_prd) m_cnt = 0;
                else m_cnt = m_cnt + 1;
            end
            if (zev) begin m_prd = m_prd_sh; m_cmp = m_cmp_sh; end
            if (prd_wr) m_prd_sh = int'(prd_wdata);
            if (cmp_wr) m_cmp_sh = int'(cmp_wdata);
            if (phs_wr) m_phs = int'(phs_wdata);
        end
        cyc++;
        @(negedge clk);
        prd_wr = 0; cmp_wr = 0; phs_wr = 0; cnt_wr = 0; sync_in = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        model_reset();
        @(negedge clk);
        run(3);
        rst_n = 1;
        req = "R1";
        run(4);
        check("R1", pwm_out, 0, "reset pwm_out");
        check("R1", sync_out, 0, "reset sync_out");

        req = "R2"; tb_en = 1;
        run(35);
        check("R2", gap, 10, "zero pulse spacing");

        req = "R3"; cmp_wr = 1; cmp_wdata = 3; step();
        run(25);
        hi = 0;
        for (int i = 0; i < 10; i++) begin if (pwm_out) hi++; step(); end
        check("R3", hi, 3, "high cycles with compare 3");
        cmp_wr = 1; cmp_wdata = 0; step(); run(22);
        hi = 0;
        for (int i = 0; i < 10; i++) begin if (pwm_out) hi++; step(); end
        check("R3", hi, 0, "high cycles with compare 0");
        cmp_wr = 1; cmp_wdata = 20; step(); run(22);
        hi = 0;
        for (int i = 0; i < 10; i++) begin if (pwm_out) hi++; step(); end
        check("R3", hi, 10, "high cycles with compare above period");
        cmp_wr = 1; cmp_wdata = 2; step();

        req = "R4"; run(3);
        prd_wr = 1; prd_wdata = 5; step();
        run(30);
        check("R4", gap, 6, "spacing after new period");

        req = "R5"; tb_en = 0; phase_en = 1; phs_wr = 1; phs_wdata = 1; step();
        for (int i = 0; i < 8; i++) begin sync_in = 1; step(); end
        check("R5", sync_out, 0, "sync_out while disabled");
        tb_en = 1; run(5);

        req = "R6"; tb_en = 0; phase_en = 0; cnt_wr = 1; cnt_wdata = 3; step();
        run(3); tb_en = 1; run(12);
        cnt_wr = 1; cnt_wdata = 0; sync_in = 1; phase_en = 1; step(); phase_en = 0;
        run(10);

        req = "R7"; phase_en = 1; phs_wr = 1; phs_wdata = 2; step();
        for (int k = 0; k < 4; k++) begin run(4); sync_in = 1; step(); end
        phase_en = 0;
        for (int k = 0; k < 4; k++) begin run(3); sync_in = 1; step(); end
        run(8);

        req = "R8"; sync_sel = 1;
        for (int k = 0; k < 6; k++) begin sync_in = k[0]; step(); end
        sync_sel = 0; run(8);

        req = "R9"; phase_en = 1; phs_wr = 1; phs_wdata = 50; step();
        for (int k = 0; k < 3; k++) begin run(2); sync_in = 1; step(); end
        phase_en = 0; run(8);

        req = "R10"; phase_en = 1; phs_wr = 1; phs_wdata = 1; step();
        prd_wr = 1; prd_wdata = 7; step();
        while (m_cnt != 0) step();
        sync_in = 1; step();
        phase_en = 0;
        run(30);
        check("R10", gap, 8, "spacing after delayed transfer");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule